// File: doc/BRIEF.md
# Iterative Integer Divide Unit

This block computes 32-bit integer quotients and remainders, signed and unsigned, for a simple processor execute stage. The caller raises a one-cycle start strobe with two operands and a 2-bit operation code. The unit holds `busy_o` high while it works. In the cycle where the answer is valid it drops `busy_o` and raises `done_o` for one cycle.

Signed operands are first turned into magnitudes. A restoring long-division loop then produces one quotient bit per clock, starting from the top bit of the dividend. After the loop, the signs of the quotient and remainder are put back. Two cases skip the loop:

- a zero divisor;
- a divisor whose magnitude is one.

The unit also keeps the operand values of its last finished job. A later request with the same values and the same signedness takes the quotient or remainder from the stored results. A quotient followed by a remainder of the same operands therefore costs only two cycles for the second request.

Top module: `iter_divider`

## Requirements
- R1: The operation code selects the result. Bit 0 set means unsigned and bit 1 set means remainder: 00 signed quotient, 01 unsigned quotient, 10 signed remainder, 11 unsigned remainder. Quotients truncate toward zero, and a signed remainder takes the sign of the dividend.
- R2: A request that takes the loop shows `done_o` in the 34th cycle, counting the start cycle as the first. The result is valid in that cycle.
- R3: `busy_o` is high in the start cycle and in every loop cycle. It is low in the cycle where `done_o` is high, and `done_o` lasts one cycle.
- R4: A start strobe is ignored unless the unit is idle. The running job finishes with its own operands and timing.
- R5: A zero divisor raises no error and takes the short path (`done_o` in the 2nd cycle). The quotient is all ones and the remainder equals the dividend.
- R6: A divisor of one, or of minus one for signed codes, takes the short path. An unsigned divisor of all ones takes the full loop.
- R7: The most negative dividend divided by minus one, signed, gives the dividend as the quotient and zero as the remainder.
- R8: A request whose operand values and signedness equal those of the last finished job skips the loop (`done_o` in the 2nd cycle). It returns the value for the newly requested code.
- R9: A request with a changed operand value, or a changed signedness, takes the full loop.
- R10: After reset, `busy_o` and `done_o` are low and no stored result counts as valid.
- R11: After `done_o`, `result_o` stays unchanged until the next accepted start strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| exec_i | input | 1 | Start strobe, taken only when idle |
| op_i | input | 2 | Operation code (bit0 unsigned, bit1 remainder) |
| dividend_i | input | 32 | Dividend operand |
| divisor_i | input | 32 | Divisor operand |
| busy_o | output | 1 | High from the start strobe until the result cycle |
| done_o | output | 1 | One-cycle result-valid pulse |
| result_o | output | 32 | Quotient or remainder |

## Verification
The hardest situation to reach is a reuse of stored results. It needs a finished job followed by a request with identical operand values and the same signedness, and nothing else. The bench issues deliberate back-to-back pairs: quotient then remainder of the same values, the same values with the other signedness, and pairs where one operand changes by a single value. A behavioural model decides cycle by cycle whether each request should hit, so a wrong hit or a missed hit shows up as a latency mismatch. Start strobes injected in the middle of a loop check that requests arriving while busy are dropped.

// File: rtl/iter_div_pkg.sv
// Shared types for the iterative divider.
// Assumes: the operation code keeps the low two bits of the instruction's
// function field, so its bit positions are fixed by the decoder.
package iter_div_pkg;

    // Control sequence of the divider.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_LOOP = 2'd1,
        ST_DONE = 2'd2
    } div_state_t;

    // Bit positions inside the operation code.
    localparam int OP_UNS_BIT = 0;
    localparam int OP_REM_BIT = 1;

endpackage

// File: rtl/iter_div_mag.sv
// Magnitude of an operand.
// Returns the absolute value when the operand is treated as signed and is
// negative; otherwise passes it through. The most negative value maps to
// itself, which reads correctly as an unsigned magnitude.
module iter_div_mag #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    input  logic         signed_i,
    output logic [W-1:0] mag_o
);

    // Purpose: negate negative signed operands.
    always_comb begin
        if (signed_i && val_i[W-1]) begin
            mag_o = {W{1'b0}} - val_i;
        end else begin
            mag_o = val_i;
        end
    end

endmodule

// File: rtl/iter_div_step.sv
// One restoring long-division step.
// Shifts the partial remainder left, brings in the next dividend bit and
// subtracts the divisor when the trial value is large enough.
// Assumes rem_i < div_i on entry, so the new remainder fits in W bits.
module iter_div_step #(
    parameter int W = 32
) (
    input  logic [W-1:0] rem_i,
    input  logic         bit_i,
    input  logic [W-1:0] div_i,
    output logic [W-1:0] rem_o,
    output logic         take_o
);

    logic [W:0] trial;

    // Purpose: build the shifted trial remainder.
    assign trial = {rem_i, bit_i};

    // Purpose: compare, then subtract or keep (modular low bits suffice).
    always_comb begin
        take_o = (trial >= {1'b0, div_i});
        if (take_o) begin
            rem_o = trial[W-1:0] - div_i;
        end else begin
            rem_o = trial[W-1:0];
        end
    end

endmodule

// File: rtl/iter_div_fix.sv
// Result selection and sign restoration.
// Picks quotient or remainder and reapplies the signs recorded at start.
// A zero divisor overrides both: all ones for the quotient, the raw
// dividend for the remainder.
module iter_div_fix #(
    parameter int W = 32
) (
    input  logic [W-1:0] q_mag_i,
    input  logic [W-1:0] r_mag_i,
    input  logic         neg_q_i,
    input  logic         neg_r_i,
    input  logic         zero_div_i,
    input  logic [W-1:0] dividend_i,
    input  logic         want_rem_i,
    output logic [W-1:0] res_o
);

    logic [W-1:0] q_signed;
    logic [W-1:0] r_signed;

    // Purpose: restore signs of quotient and remainder.
    always_comb begin
        q_signed = neg_q_i ? ({W{1'b0}} - q_mag_i) : q_mag_i;
        r_signed = neg_r_i ? ({W{1'b0}} - r_mag_i) : r_mag_i;
    end

    // Purpose: choose the output value, zero divisor first.
    always_comb begin
        if (zero_div_i) begin
            res_o = want_rem_i ? dividend_i : {W{1'b1}};
        end else begin
            res_o = want_rem_i ? r_signed : q_signed;
        end
    end

endmodule

// File: rtl/iter_divider.sv
// Iterative integer divide unit (top).
// Accepts a start strobe only when idle. Full jobs run W loop cycles,
// plus a start cycle and a result cycle. A zero divisor, a divisor of
// magnitude one, or a repeat of the last operand values with the same
// signedness goes straight to the result cycle.
// Assumes the caller holds off a new strobe until busy_o falls.
module iter_divider
    import iter_div_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         exec_i,
    input  logic [1:0]   op_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic         busy_o,
    output logic         done_o,
    output logic [W-1:0] result_o
);

    localparam int          CW   = $clog2(W);
    localparam logic [CW-1:0] LAST = CW'(W - 1);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    div_state_t   state_q;
    logic [CW-1:0] cnt_q;
    logic [1:0]   op_q;
    logic [W-1:0] a_q, b_q;
    logic         uns_q;
    logic         valid_q;
    logic [W-1:0] dvd_q, dvs_q, rem_q, quo_q;
    logic         negq_q, negr_q, dz_q;

    logic         accept;
    logic         op_signed;
    logic [W-1:0] a_mag, b_mag;
    logic         cache_hit;
    logic         short_path;
    logic [W-1:0] step_rem;
    logic         step_bit;

    // Purpose: a start strobe counts only in the idle state.
    assign accept    = (state_q == ST_IDLE) && exec_i;
    assign op_signed = ~op_i[OP_UNS_BIT];

    iter_div_mag #(.W(W)) u_mag_dvd (
        .val_i    (dividend_i),
        .signed_i (op_signed),
        .mag_o    (a_mag)
    );

    iter_div_mag #(.W(W)) u_mag_dvs (
        .val_i    (divisor_i),
        .signed_i (op_signed),
        .mag_o    (b_mag)
    );

    // Purpose: detect reuse of the last finished job's values.
    assign cache_hit = valid_q && (dividend_i == a_q) && (divisor_i == b_q)
                       && (op_i[OP_UNS_BIT] == uns_q);

    // Purpose: divisors that need no loop.
    assign short_path = (divisor_i == {W{1'b0}}) || (b_mag == ONE);

    iter_div_step #(.W(W)) u_step (
        .rem_i  (rem_q),
        .bit_i  (dvd_q[W-1]),
        .div_i  (dvs_q),
        .rem_o  (step_rem),
        .take_o (step_bit)
    );

    // Purpose: control sequence, operand capture and loop datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            op_q    <= '0;
            a_q     <= '0;
            b_q     <= '0;
            uns_q   <= 1'b0;
            valid_q <= 1'b0;
            dvd_q   <= '0;
            dvs_q   <= '0;
            rem_q   <= '0;
            quo_q   <= '0;
            negq_q  <= 1'b0;
            negr_q  <= 1'b0;
            dz_q    <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        op_q <= op_i;
                        if (cache_hit) begin
                            state_q <= ST_DONE;
                        end else begin
                            a_q     <= dividend_i;
                            b_q     <= divisor_i;
                            uns_q   <= op_i[OP_UNS_BIT];
                            negq_q  <= op_signed &
                                       (dividend_i[W-1] ^ divisor_i[W-1]);
                            negr_q  <= op_signed & dividend_i[W-1];
                            dz_q    <= (divisor_i == {W{1'b0}});
                            dvs_q   <= b_mag;
                            rem_q   <= '0;
                            cnt_q   <= '0;
                            if (short_path) begin
                                quo_q   <= a_mag;
                                valid_q <= 1'b1;
                                state_q <= ST_DONE;
                            end else begin
                                quo_q   <= '0;
                                dvd_q   <= a_mag;
                                valid_q <= 1'b0;
                                state_q <= ST_LOOP;
                            end
                        end
                    end
                end
                ST_LOOP: begin
                    rem_q <= step_rem;
                    quo_q <= {quo_q[W-2:0], step_bit};
                    dvd_q <= {dvd_q[W-2:0], 1'b0};
                    cnt_q <= cnt_q + CW'(1);
                    if (cnt_q == LAST) begin
                        valid_q <= 1'b1;
                        state_q <= ST_DONE;
                    end
                end
                ST_DONE: begin
                    state_q <= ST_IDLE;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    iter_div_fix #(.W(W)) u_fix (
        .q_mag_i    (quo_q),
        .r_mag_i    (rem_q),
        .neg_q_i    (negq_q),
        .neg_r_i    (negr_q),
        .zero_div_i (dz_q),
        .dividend_i (a_q),
        .want_rem_i (op_q[OP_REM_BIT]),
        .res_o      (result_o)
    );

    // Purpose: handshake outputs.
    assign busy_o = (state_q == ST_LOOP) || accept;
    assign done_o = (state_q == ST_DONE);

    // R3: the loop keeps busy high and never reports a result.
    a_r3_busy_in_loop: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOP) |-> (busy_o && !done_o));

    // R3: busy and done never overlap.
    a_r3_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    // R2: the last loop step leads straight to the result cycle.
    a_r2_loop_exit: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOP && cnt_q == LAST) |=> done_o);

    // R4: strobes during the loop leave the captured operands alone.
    a_r4_ignore_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOP && exec_i) |=> ($stable(a_q) && $stable(b_q)));

    // R5: a zero divisor yields all ones as the quotient.
    a_r5_zero_quot: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && dz_q && !op_q[OP_REM_BIT]) |-> (result_o == {W{1'b1}}));

    // R8: a reuse of stored values gives the result next cycle.
    a_r8_hit_fast: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && cache_hit) |=> done_o);

    // R1: every loop step leaves the remainder below the divisor.
    a_r1_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_LOOP) |=> (rem_q < dvs_q));

    // R11: the result holds in the idle cycle after the result cycle.
    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && $past(state_q) == ST_DONE) |-> $stable(result_o));

endmodule

// File: tb/tb_iter_divider.sv
// Bench: behavioural cycle model compared against the ports every clock.
module tb_iter_divider;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        exec_i = 1'b0;
    logic [1:0]  op_i = 2'b00;
    logic [31:0] dividend_i = '0;
    logic [31:0] divisor_i = '0;
    logic        busy_o, done_o;
    logic [31:0] result_o;

    int errors = 0;
    int checks = 0;
    string cur_tag = "R10";

    // Model state.
    bit          m_loop = 0;
    bit          m_cmp = 0;
    int          m_left = 0;
    bit          m_valid = 0;
    bit          m_have = 0;
    logic [31:0] m_a = '0, m_b = '0;
    bit          m_uns = 0;
    logic [31:0] m_res = '0;
    bit          live = 0;

    iter_divider dut (
        .clk(clk), .rst_n(rst_n), .exec_i(exec_i), .op_i(op_i),
        .dividend_i(dividend_i), .divisor_i(divisor_i),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o)
    );

    always #(CLK_P/2) clk = ~clk;

    function automatic logic [31:0] ref_calc(logic [31:0] a, logic [31:0] b,
                                             logic [1:0] op);
        longint sa, sb, q, r;
        longint unsigned ua, ub, uq, ur;
        if (b == 0) return op[1] ? a : 32'hFFFF_FFFF;
        if (op[0]) begin
            ua = a; ub = b; uq = ua / ub; ur = ua % ub;
            return op[1] ? ur[31:0] : uq[31:0];
        end
        sa = $signed(a); sb = $signed(b); q = sa / sb; r = sa % sb;
        return op[1] ? r[31:0] : q[31:0];
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Model update at each active edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_loop = 0; m_cmp = 0; m_valid = 0; m_have = 0;
        end else if (!m_loop && !m_cmp && exec_i) begin
            bit hit, shrt;
            hit  = m_valid && dividend_i == m_a && divisor_i == m_b && op_i[0] == m_uns;
            shrt = (divisor_i == 0) || (divisor_i == 1) ||
                   (!op_i[0] && divisor_i == 32'hFFFF_FFFF);
            m_res = ref_calc(dividend_i, divisor_i, op_i);
            m_a = dividend_i; m_b = divisor_i; m_uns = op_i[0];
            m_valid = 1; m_have = 1;
            if (hit || shrt) begin m_cmp = 1; end
            else begin m_loop = 1; m_left = 32; end
        end else if (m_loop) begin
            m_left--;
            if (m_left == 0) begin m_loop = 0; m_cmp = 1; end
        end else begin
            m_cmp = 0;
        end
    end

    // Port comparison every clock, away from the active edge.
    always @(negedge clk) begin
        if (live) begin
            bit eb;
            eb = m_loop || (!m_cmp && exec_i);
            chk(busy_o == eb, "R3", "busy", {31'b0, busy_o}, {31'b0, eb});
            chk(done_o == m_cmp, "R2", "done", {31'b0, done_o}, {31'b0, m_cmp});
            if (m_cmp)
                chk(result_o == m_res, cur_tag, "result", result_o, m_res);
            else if (!m_loop && m_have)
                chk(result_o == m_res, "R11", "held result", result_o, m_res);
        end
    end

    task automatic wait_idle();
        while (m_loop || m_cmp) begin @(posedge clk); #1; end
    endtask

    task automatic run(input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] op, input string tag);
        @(posedge clk); #1;
        wait_idle();
        cur_tag = tag;
        dividend_i = a; divisor_i = b; op_i = op; exec_i = 1;
        @(posedge clk); #1;
        exec_i = 0;
        wait_idle();
    endtask

    // R4: strobe with other operands in the middle of a loop.
    task automatic run_disturbed(input logic [31:0] a, input logic [31:0] b,
                                 input logic [1:0] op);
        @(posedge clk); #1;
        wait_idle();
        cur_tag = "R4";
        dividend_i = a; divisor_i = b; op_i = op; exec_i = 1;
        @(posedge clk); #1;
        exec_i = 0;
        repeat (5) begin @(posedge clk); #1; end
        dividend_i = 32'd9; divisor_i = 32'd0; op_i = 2'b11; exec_i = 1;
        @(posedge clk); #1;
        exec_i = 0;
        wait_idle();
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R10: idle outputs after reset.
        chk(busy_o == 0, "R10", "busy after reset", {31'b0, busy_o}, 32'd0);
        chk(done_o == 0, "R10", "done after reset", {31'b0, done_o}, 32'd0);
        live = 1;
        // R1: all four codes, mixed signs.
        run(32'd100, 32'd7, 2'b00, "R1");
        run(-32'sd100, 32'd7, 2'b00, "R1");
        run(32'd100, -32'sd7, 2'b10, "R1");
        run(-32'sd100, -32'sd7, 2'b10, "R1");
        run(-32'sd100, 32'd7, 2'b01, "R1");
        run(32'hFFFF_FFFF, 32'd3, 2'b11, "R1");
        run(32'hFFFF_FFFF, 32'h8000_0000, 2'b01, "R1");
        run(32'd5, 32'd9, 2'b00, "R1");
        // R5: zero divisor, each code.
        run(-32'sd42, 32'd0, 2'b00, "R5");
        run(-32'sd42, 32'd0, 2'b10, "R5");
        run(32'd42, 32'd0, 2'b01, "R5");
        run(32'd43, 32'd0, 2'b11, "R5");
        // R6: unit divisors.
        run(32'd1234, 32'd1, 2'b01, "R6");
        run(32'd1234, -32'sd1, 2'b00, "R6");
        run(32'd77, -32'sd1, 2'b10, "R6");
        run(32'd1234, 32'hFFFF_FFFF, 2'b01, "R6");
        // R7: signed overflow.
        run(32'h8000_0000, 32'hFFFF_FFFF, 2'b00, "R7");
        run(32'h8000_0000, 32'hFFFF_FFFF, 2'b10, "R7");
        // R8: reuse of stored results.
        run(32'd1000, -32'sd33, 2'b00, "R8");
        run(32'd1000, -32'sd33, 2'b10, "R8");
        run(32'd99999, 32'd13, 2'b11, "R8");
        run(32'd99999, 32'd13, 2'b01, "R8");
        // R9: changed value or signedness forces the loop.
        run(32'd99999, 32'd13, 2'b00, "R9");
        run(32'd99998, 32'd13, 2'b10, "R9");
        run(32'd99998, 32'd14, 2'b10, "R9");
        // R4: strobe while busy.
        run_disturbed(32'd5000, 32'd17, 2'b00);
        // R11: idle gap, model checks the held value.
        repeat (6) @(posedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule